// File: doc/BRIEF.md
# Buffered Page Write Commit Engine

This block sits behind a serial memory front end and owns the write path into a byte-wide non-volatile array. While a write command is open it stages the incoming data bytes in a local 256-entry buffer, and it does not touch the array. When the front end reports that chip select has gone high, the block replays the staged bytes into the array through a simple write port, one byte per clock. It then holds a busy flag for a parameterised program time, which models the slow cell programming.

The starting address comes with a load strobe at the beginning of each command. Each data byte arrives with its own strobe. The address advances by one per byte and wraps from the top of the array back to zero. The block samples the two block-protect bits and the write-enable latch from the status logic when the command closes. A byte whose address falls inside the protected region still takes its commit cycle, but no write is issued for it. When programming ends, busy drops and a one-cycle done pulse tells the status logic to clear its write-enable latch.

Top module: `pwc_page_commit`

## Requirements
- R1: Out of reset, busy, done and mem_we are all 0.
- R2: Bytes strobed while busy is low are staged in arrival order. At most 256 are kept per command, and the strobes after the 256th are dropped. The k-th staged byte is the data written for the k-th commit slot.
- R3: A cs_rise while idle, with at least one staged byte and wel = 1, raises busy on the next cycle. The write of the first staged byte is presented on the write port in that same cycle.
- R4: Commit slot k (counting from 0) is presented in the k-th busy cycle at address (base + k) mod 2^19, so 0x7FFFF is followed by 0x00000. Successive writes go to successive addresses.
- R5: The protect field bp, sampled at cs_rise (bp[1] is the upper bit), decides which slots are skipped. 00 protects nothing. 01 protects addresses 0x60000 and above. 10 protects 0x40000 and above. 11 protects every address. A skipped slot drives mem_we low and still takes its cycle, and the slots after it are written normally.
- R6: For a commit of N bytes, busy stays high for exactly N + PROG_CYCLES cycles. done pulses high for one cycle, in the first cycle in which busy is low again. done is the request to clear the write-enable latch.
- R7: A cs_rise with wel = 0 starts nothing: busy stays low, no write and no done occur, and the staged bytes are discarded.
- R8: A cs_rise with no staged byte does not raise busy and does not pulse done.
- R9: While busy is high, cmd_load, byte_stb and cs_rise are ignored. No byte offered during a commit is staged.
- R10: A byte strobed in the same cycle as cs_rise is part of the closing burst. A byte strobed in the same cycle as cmd_load is the first byte of the new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_load | input | 1 | Opens a write command and loads its start address |
| cmd_addr | input | 19 | Start address of the command |
| byte_stb | input | 1 | One data byte is present on byte_data |
| byte_data | input | 8 | Data byte to stage |
| cs_rise | input | 1 | Chip select rising event that closes the command |
| bp | input | 2 | Block-protect level from the status logic |
| wel | input | 1 | Write-enable latch from the status logic |
| busy | output | 1 | Commit or program time in progress |
| done | output | 1 | One-cycle pulse at the end of programming; clear the write-enable latch |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 19 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
Two functions can fall in the same cycle. The closing cs_rise can coincide with a final byte strobe, and a command load can coincide with the first data byte. The bench drives both overlaps on purpose. The reference model then decides from its own queue whether the byte belongs to the burst, and the number of writes and their addresses on the port are compared. Within a single commit slot, address wrap and the protection boundary can also meet. Bursts that start just below 0x7FFFF under protect levels 00 and 10 show whether the wrapped slots are written and the protected ones are skipped.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_PROG  = 2'd2
  } phase_e;
endpackage

// File: rtl/pwc_stage_buf.sv
module pwc_stage_buf #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              drop,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  fill_nxt
);
  logic [DATA_W-1:0] store_q [DEPTH];
  logic [CNT_W-1:0]  fill_q, fill_d, base_cnt;
  logic              room, wr_ok, fill_en;

  // restart empties the buffer before any byte of the same cycle lands
  always_comb begin
    base_cnt = restart ? '0 : fill_q;
    room     = base_cnt < CNT_W'(DEPTH);
    wr_ok    = push && room;
    fill_nxt = base_cnt + CNT_W'(wr_ok);
    fill_d   = drop ? '0 : fill_nxt;
    fill_en  = restart || push || drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fill_q <= '0;
    else if (fill_en) fill_q <= fill_d;
  end

  // data storage carries no reset; only the fill count qualifies it
  always_ff @(posedge clk) begin
    if (wr_ok) store_q[base_cnt[IDX_W-1:0]] <= din;
  end

  assign rd_data = store_q[rd_idx];

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/pwc_guard.sv
module pwc_guard #(
  parameter int ADDR_W = 19
) (
  input  logic [1:0]        level,
  input  logic [ADDR_W-1:0] addr,
  output logic              allowed
);
  logic top_half, top_quarter;

  always_comb begin
    top_half    = addr[ADDR_W-1];
    top_quarter = addr[ADDR_W-1] && addr[ADDR_W-2];
    unique case (level)
      2'b00:   allowed = 1'b1;
      2'b01:   allowed = !top_quarter;
      2'b10:   allowed = !top_half;
      default: allowed = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwc_commit_fsm.sv
module pwc_commit_fsm
  import pwc_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int PROG_CYCLES = 16,
  parameter int PC_W        = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] idx,
  output logic             writing,
  output logic             busy,
  output logic             done
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] idx_q, idx_d, len_q, len_d;
  logic [PC_W-1:0]  pcnt_q, pcnt_d;
  logic             done_d;
  logic             idx_en, len_en, pcnt_en;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    len_d   = len_q;
    pcnt_d  = pcnt_q;
    done_d  = 1'b0;
    idx_en  = 1'b0;
    len_en  = 1'b0;
    pcnt_en = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (go) begin
          phase_d = PH_WRITE;
          idx_d   = '0;
          idx_en  = 1'b1;
          len_d   = len;
          len_en  = 1'b1;
        end
      end
      PH_WRITE: begin
        if (idx_q == len_q - CNT_W'(1)) begin
          phase_d = PH_PROG;
          pcnt_d  = PC_W'(PROG_CYCLES - 1);
          pcnt_en = 1'b1;
        end else begin
          idx_d  = idx_q + CNT_W'(1);
          idx_en = 1'b1;
        end
      end
      PH_PROG: begin
        if (pcnt_q == '0) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end else begin
          pcnt_d  = pcnt_q - PC_W'(1);
          pcnt_en = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
      pcnt_q  <= '0;
      done_q_r: done <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done    <= done_d;
      if (idx_en)  idx_q  <= idx_d;
      if (len_en)  len_q  <= len_d;
      if (pcnt_en) pcnt_q <= pcnt_d;
    end
  end

  assign idx     = idx_q;
  assign writing = (phase_q == PH_WRITE);
  assign busy    = (phase_q != PH_IDLE);

  // R6
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R3
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(go) && writing && idx == '0));
endmodule

// File: rtl/pwc_page_commit.sv
module pwc_page_commit #(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 256,
  parameter int PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_load,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              cs_rise,
  input  logic [1:0]        bp,
  input  logic              wel,
  output logic              busy,
  output logic              done,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              idle, ld, stb, fin, go;
  logic [CNT_W-1:0]  fill_nxt, idx;
  logic              writing, allowed;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        bp_q;

  // every front-end event is dropped while a commit is running
  always_comb begin
    idle = !busy;
    ld   = cmd_load && idle;
    stb  = byte_stb && idle;
    fin  = cs_rise && idle;
    go   = fin && wel && (fill_nxt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      bp_q   <= '0;
    end else begin
      if (ld) base_q <= cmd_addr;
      if (go) bp_q   <= bp;
    end
  end

  pwc_stage_buf #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W)
  ) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (ld),
    .push     (stb),
    .din      (byte_data),
    .drop     (fin),
    .rd_idx   (idx[IDX_W-1:0]),
    .rd_data  (mem_wdata),
    .fill_nxt (fill_nxt)
  );

  pwc_commit_fsm #(
    .CNT_W       (CNT_W),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .len     (fill_nxt),
    .idx     (idx),
    .writing (writing),
    .busy    (busy),
    .done    (done)
  );

  // address arithmetic wraps naturally at the array top
  assign mem_addr = base_q + ADDR_W'(idx);

  pwc_guard #(
    .ADDR_W (ADDR_W)
  ) u_guard (
    .level   (bp_q),
    .addr    (mem_addr),
    .allowed (allowed)
  );

  assign mem_we = writing && allowed;

  // R3
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R5
  full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (bp_q != 2'b11));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  // R7
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && wel));
endmodule

// File: tb/test_pwc_page_commit.sv
module test_pwc_page_commit;
  localparam int AW = 19;
  localparam int DEPTH = 256;
  localparam int PROG = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, cmd_load, byte_stb, cs_rise, wel;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    byte_data;
  logic [1:0]    bp;
  logic          busy, done, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;

  pwc_page_commit #(.ADDR_W(AW), .DATA_W(8), .DEPTH(DEPTH), .PROG_CYCLES(PROG))
    i_pwc_page_commit (
      .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_addr(cmd_addr),
      .byte_stb(byte_stb), .byte_data(byte_data), .cs_rise(cs_rise),
      .bp(bp), .wel(wel), .busy(busy), .done(done), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  int n_chk = 0, n_fail = 0;
  int wr_count = 0, busy_cycles = 0, done_count = 0;
  bit finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit prot(logic [1:0] l, int a);
    case (l)
      2'd0:    return 1'b0;
      2'd1:    return a >= 32'h60000;
      2'd2:    return a >= 32'h40000;
      default: return 1'b1;
    endcase
  endfunction

  // behavioural reference model
  bit         m_busy, m_done;
  int         m_t, m_len, m_base;
  logic [1:0] m_bp;
  logic [7:0] q[$];
  logic [7:0] snap[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_t = 0; m_len = 0; m_base = 0; m_bp = 0;
      q.delete(); snap.delete();
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_t++;
        if (m_t == m_len + PROG) begin m_busy = 0; m_done = 1; end
      end else begin
        if (cmd_load) begin q.delete(); m_base = int'(cmd_addr); end
        if (byte_stb && q.size() < DEPTH) q.push_back(byte_data);
        if (cs_rise) begin
          if (q.size() > 0 && wel) begin
            m_busy = 1; m_t = 0; m_len = q.size(); m_bp = bp; snap = q;
          end
          q.delete();
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int  ea;
      bit  ew;
      ea = (m_base + m_t) % (1 << AW);
      ew = m_busy && (m_t < m_len) && !prot(m_bp, ea);
      chk("R6", "busy", int'(busy), int'(m_busy));
      chk("R6", "done", int'(done), int'(m_done));
      chk("R5", "mem_we", int'(mem_we), int'(ew));
      if (ew) begin
        chk("R4", "mem_addr", int'(mem_addr), ea);
        chk("R2", "mem_wdata", int'(mem_wdata), int'(snap[m_t]));
      end
      if (mem_we) wr_count++;
      if (busy) busy_cycles++;
      if (done) done_count++;
    end
  end

  // drivers: called at a falling edge, return at a falling edge
  task automatic load(int a);
    cmd_load = 1; cmd_addr = AW'(a);
    @(negedge clk); cmd_load = 0;
  endtask

  task automatic put(logic [7:0] d);
    byte_stb = 1; byte_data = d;
    @(negedge clk); byte_stb = 0;
  endtask

  task automatic close();
    cs_rise = 1;
    @(negedge clk); cs_rise = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_counts();
    wr_count = 0; busy_cycles = 0; done_count = 0;
  endtask

  task automatic burst(int a, int n, logic [1:0] lvl, logic en, int seed);
    clear_counts();
    bp = lvl; wel = en;
    load(a);
    for (int i = 0; i < n; i++) put(8'(seed + i * 7));
    close();
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R6 watchdog expired: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_load = 0; byte_stb = 0; cs_rise = 0; wel = 0; bp = 0;
    cmd_addr = '0; byte_data = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset done", int'(done), 0);
    chk("R1", "reset mem_we", int'(mem_we), 0);
    rst_n = 1;
    @(negedge clk);

    // R3 plain burst
    burst(32'h100, 4, 2'b00, 1'b1, 8'h11);
    chk("R3", "writes basic", wr_count, 4);
    chk("R6", "busy length", busy_cycles, 4 + PROG);
    chk("R6", "done pulses", done_count, 1);

    // R4 wrap at the array top
    burst(32'h7FFFE, 5, 2'b00, 1'b1, 8'h40);
    chk("R4", "writes across wrap", wr_count, 5);

    // R5 unprotected into protected, and wrap out of protected
    burst(32'h5FFFE, 4, 2'b01, 1'b1, 8'h60);
    chk("R5", "writes bp01 crossing", wr_count, 2);
    burst(32'h7FFFE, 4, 2'b10, 1'b1, 8'h70);
    chk("R5", "writes bp10 wrap", wr_count, 2);
    burst(32'h00010, 3, 2'b11, 1'b1, 8'h80);
    chk("R5", "writes bp11", wr_count, 0);
    chk("R6", "busy length bp11", busy_cycles, 3 + PROG);

    // R2 overflow beyond the buffer
    burst(32'h20000, 300, 2'b00, 1'b1, 8'h05);
    chk("R2", "writes capped", wr_count, DEPTH);
    chk("R6", "busy length full", busy_cycles, DEPTH + PROG);

    // R7 latch clear
    burst(32'h00200, 3, 2'b00, 1'b0, 8'h90);
    chk("R7", "writes wel0", wr_count, 0);
    chk("R7", "busy wel0", busy_cycles, 0);
    chk("R7", "done wel0", done_count, 0);

    // R8 empty command
    burst(32'h00300, 0, 2'b00, 1'b1, 8'h00);
    chk("R8", "busy empty", busy_cycles, 0);
    chk("R8", "done empty", done_count, 0);

    // R9 traffic during a commit is ignored
    clear_counts();
    bp = 2'b00; wel = 1;
    load(32'h00400);
    put(8'hA1); put(8'hA2);
    close();
    @(negedge clk);
    load(32'h00000);
    put(8'hEE); put(8'hEF);
    close();
    settle();
    chk("R9", "writes while busy", wr_count, 2);
    chk("R9", "done while busy", done_count, 1);
    clear_counts();
    close();
    settle();
    chk("R9", "no staged bytes after busy", busy_cycles, 0);

    // R10 byte with closing event, byte with load
    clear_counts();
    bp = 2'b00; wel = 1;
    load(32'h00500);
    put(8'hB0);
    byte_stb = 1; byte_data = 8'hB1; cs_rise = 1;
    @(negedge clk); byte_stb = 0; cs_rise = 0;
    settle();
    chk("R10", "byte with cs_rise", wr_count, 2);
    clear_counts();
    cmd_load = 1; cmd_addr = AW'(32'h00600); byte_stb = 1; byte_data = 8'hC0;
    @(negedge clk); cmd_load = 0; byte_stb = 0;
    put(8'hC1);
    close();
    settle();
    chk("R10", "byte with load", wr_count, 2);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule